// File: doc/BRIEF.md
# Time-Slot Switch Output Selector

This block decides, slot by slot, what byte leaves on each transmit stream of a time-slot switch and whether that stream's driver is switched on. Each of the 512 output slots (16 streams by 32 channels) owns one connection-memory entry. The entry picks one of two modes. In switched mode it names a source stream and channel whose received byte is fetched from the data memory. In processor mode it supplies the transmitted byte itself. The entry also carries a driver-enable bit, a loopback bit and a delay-mode flag.

Received bytes are written into the data memory by slot address. When a slot's loopback bit is set, that slot's data-memory location is fed from its own transmitted byte rather than from the receive side. Driver enables combine a global enable pin, a software standby-enable bit and the per-entry enable bit. With both global controls low, every driver is off, so the connection memory can be loaded safely after power-up.

A slot address is formed as stream times 32 plus channel. Transmit results are requested one slot at a time and returned two clock edges later.

Top module: `tss_out_select`

## Requirements
- R1: When the entry's processor bit (bit 9) is set, tx_byte equals the entry's bits 7:0.
- R2: When the processor bit is clear, tx_byte equals the data-memory byte at the slot address held in entry bits 8:0 (bits 8:5 stream, bits 4:0 channel).
- R3: When oe_pin or oe_standby is high at the request edge, tx_oe equals the entry's enable bit (bit 10).
- R4: When oe_pin and oe_standby are both low at the request edge, tx_oe is low whatever the entry holds.
- R5: After a slot whose entry has the loopback bit (bit 11) set is transmitted, the data memory at that same slot address holds the transmitted byte.
- R6: A receive write to a slot whose entry has the loopback bit set leaves the data memory unchanged.
- R7: tx_vdelay equals the entry's delay-mode bit (bit 12).
- R8: After reset tx_valid and tx_oe are low; a tx_req at one rising edge gives tx_valid high, with that slot's results, after the following rising edge, and low one cycle earlier.
- R9: A receive write to a slot without loopback stores rx_byte at rx_addr in the data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cm_wr_en | input | 1 | Connection-memory write strobe |
| cm_wr_addr | input | 9 | Slot address of the entry written |
| cm_wr_data | input | 13 | Entry: 12 delay mode, 11 loopback, 10 enable, 9 processor, 8:0 source or byte |
| rx_wr | input | 1 | Receive byte write strobe |
| rx_addr | input | 9 | Slot address of the received byte |
| rx_byte | input | 8 | Received byte |
| oe_pin | input | 1 | Global output-enable pin |
| oe_standby | input | 1 | Software standby-enable bit |
| tx_req | input | 1 | Request the result for one output slot |
| tx_addr | input | 9 | Output slot requested |
| tx_valid | output | 1 | Results below belong to the request two edges back |
| tx_byte | output | 8 | Byte for the output slot |
| tx_oe | output | 1 | Driver enable for the output slot |
| tx_vdelay | output | 1 | Delay-mode flag of the output slot |

## Verification
A request sampled at one rising edge reads its entry there, reads the data memory and fires any loopback write at the next edge, so tx_byte, tx_oe, tx_vdelay and tx_valid become due just after that second edge. The bench drives on falling edges and leaves two idle cycles after every request, checking tx_valid low at the first falling edge and all results at the second; because requests never overlap, the reference model can apply each loopback write before the next read. Connection and receive writes each take one edge and are followed by a request only after they have landed.

// File: rtl/tss_pkg.sv
package tss_pkg;
    localparam int NUM_STREAMS = 16;
    localparam int NUM_CHANS   = 32;
    localparam int BYTE_W      = 8;
    localparam int STREAM_W    = $clog2(NUM_STREAMS);
    localparam int CHAN_W      = $clog2(NUM_CHANS);
    localparam int SLOT_W      = STREAM_W + CHAN_W;
    localparam int NUM_SLOTS   = NUM_STREAMS * NUM_CHANS;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic                vdelay;
        logic                loopback;
        logic                oe;
        logic                proc;
        logic [STREAM_W-1:0] src_stream;
        logic [CHAN_W-1:0]   src_chan;
    } cm_entry_t;

    localparam int ENTRY_W = $bits(cm_entry_t);

    typedef struct packed {
        logic      s1_valid;
        slot_t     s1_addr;
        cm_entry_t s1_entry;
        logic      s1_en;
        logic      out_valid;
        byte_t     out_byte;
        logic      out_oe;
        logic      out_vdelay;
    } pipe_t;
endpackage

// File: rtl/tss_conn_mem.sv
module tss_conn_mem
    import tss_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  slot_t     wr_addr,
    input  cm_entry_t wr_data,
    input  slot_t     rd_a_addr,
    output cm_entry_t rd_a,
    input  slot_t     rd_b_addr,
    output cm_entry_t rd_b
);
    cm_entry_t mem_q [NUM_SLOTS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_a = mem_q[rd_a_addr];
    assign rd_b = mem_q[rd_b_addr];

    // Entry written is the entry later looked up (basis of R1, R2)
    assert_cm_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/tss_data_mem.sv
module tss_data_mem
    import tss_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rx_wr,
    input  slot_t rx_addr,
    input  byte_t rx_byte,
    input  logic  rx_block,
    input  logic  lb_wr,
    input  slot_t lb_addr,
    input  byte_t lb_byte,
    input  slot_t rd_addr,
    output byte_t rd_byte
);
    byte_t mem_q [NUM_SLOTS];

    always_ff @(posedge clk) begin
        if (rx_wr && !rx_block) begin
            mem_q[rx_addr] <= rx_byte;
        end
        if (lb_wr) begin
            mem_q[lb_addr] <= lb_byte;
        end
    end

    assign rd_byte = mem_q[rd_addr];

    assert_loop_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lb_wr |=> mem_q[$past(lb_addr)] == $past(lb_byte));
endmodule

// File: rtl/tss_out_select.sv
module tss_out_select
    import tss_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cm_wr_en,
    input  logic [SLOT_W-1:0]  cm_wr_addr,
    input  logic [ENTRY_W-1:0] cm_wr_data,
    input  logic               rx_wr,
    input  logic [SLOT_W-1:0]  rx_addr,
    input  logic [BYTE_W-1:0]  rx_byte,
    input  logic               oe_pin,
    input  logic               oe_standby,
    input  logic               tx_req,
    input  logic [SLOT_W-1:0]  tx_addr,
    output logic               tx_valid,
    output logic [BYTE_W-1:0]  tx_byte,
    output logic               tx_oe,
    output logic               tx_vdelay
);
    pipe_t     st_d, st_q;
    cm_entry_t cm_tx, cm_rx;
    byte_t     dm_rd, sel_byte;
    slot_t     src_addr;
    logic      lb_wr;

    tss_conn_mem u_cm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cm_wr_en),
        .wr_addr   (cm_wr_addr),
        .wr_data   (cm_entry_t'(cm_wr_data)),
        .rd_a_addr (tx_addr),
        .rd_a      (cm_tx),
        .rd_b_addr (rx_addr),
        .rd_b      (cm_rx)
    );

    assign src_addr = {st_q.s1_entry.src_stream, st_q.s1_entry.src_chan};
    assign lb_wr    = st_q.s1_valid && st_q.s1_entry.loopback;

    tss_data_mem u_dm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_wr    (rx_wr),
        .rx_addr  (rx_addr),
        .rx_byte  (rx_byte),
        .rx_block (cm_rx.loopback),
        .lb_wr    (lb_wr),
        .lb_addr  (st_q.s1_addr),
        .lb_byte  (sel_byte),
        .rd_addr  (src_addr),
        .rd_byte  (dm_rd)
    );

    always_comb begin
        sel_byte = st_q.s1_entry.proc ? src_addr[BYTE_W-1:0] : dm_rd;

        st_d          = st_q;
        st_d.s1_valid = tx_req;
        if (tx_req) begin
            st_d.s1_addr  = tx_addr;
            st_d.s1_entry = cm_tx;
            st_d.s1_en    = oe_pin || oe_standby;
        end

        st_d.out_valid = st_q.s1_valid;
        st_d.out_oe    = 1'b0;
        if (st_q.s1_valid) begin
            st_d.out_byte   = sel_byte;
            st_d.out_oe     = st_q.s1_en && st_q.s1_entry.oe;
            st_d.out_vdelay = st_q.s1_entry.vdelay;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid  = st_q.out_valid;
    assign tx_byte   = st_q.out_byte;
    assign tx_oe     = st_q.out_oe;
    assign tx_vdelay = st_q.out_vdelay;

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> ##1 tx_valid);

    assert_global_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !oe_pin && !oe_standby) |=> ##1 !tx_oe);

    assert_entry_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_valid && !st_q.s1_entry.oe) |=> !tx_oe);

    assert_idle_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |-> !tx_oe);
endmodule

// File: tb/tss_out_select_tb.sv
`timescale 1ns/1ps
module tss_out_select_tb;
    import tss_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst_n;
    logic               cm_wr_en;
    logic [SLOT_W-1:0]  cm_wr_addr;
    logic [ENTRY_W-1:0] cm_wr_data;
    logic               rx_wr;
    logic [SLOT_W-1:0]  rx_addr;
    logic [BYTE_W-1:0]  rx_byte;
    logic               oe_pin, oe_standby, tx_req;
    logic [SLOT_W-1:0]  tx_addr;
    logic               tx_valid, tx_oe, tx_vdelay;
    logic [BYTE_W-1:0]  tx_byte;

    tss_out_select u_dut (
        .clk(clk), .rst_n(rst_n),
        .cm_wr_en(cm_wr_en), .cm_wr_addr(cm_wr_addr), .cm_wr_data(cm_wr_data),
        .rx_wr(rx_wr), .rx_addr(rx_addr), .rx_byte(rx_byte),
        .oe_pin(oe_pin), .oe_standby(oe_standby),
        .tx_req(tx_req), .tx_addr(tx_addr),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_oe(tx_oe), .tx_vdelay(tx_vdelay)
    );

    logic [ENTRY_W-1:0] cm_m [NUM_SLOTS];
    logic [BYTE_W-1:0]  dm_m [NUM_SLOTS];
    int errors = 0;
    int checks = 0;
    bit done = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cm_write(int a, logic [ENTRY_W-1:0] d);
        cm_wr_en = 1'b1; cm_wr_addr = SLOT_W'(a); cm_wr_data = d;
        @(negedge clk);
        cm_wr_en = 1'b0;
        cm_m[a] = d;
    endtask

    task automatic rx_write(int a, logic [BYTE_W-1:0] b);
        rx_wr = 1'b1; rx_addr = SLOT_W'(a); rx_byte = b;
        @(negedge clk);
        rx_wr = 1'b0;
        if (!cm_m[a][11]) dm_m[a] = b;
    endtask

    // Request one slot, check results; tag overrides the byte requirement if non-empty
    task automatic tx_slot(int a, string tag);
        logic [ENTRY_W-1:0] e;
        logic [BYTE_W-1:0]  exp_b;
        logic               exp_oe;
        string              btag;
        e      = cm_m[a];
        exp_b  = e[9] ? e[7:0] : dm_m[e[8:0]];
        exp_oe = (oe_pin || oe_standby) && e[10];
        btag   = (tag != "") ? tag : (e[9] ? "R1 processor byte" : "R2 switched byte");
        tx_req = 1'b1; tx_addr = SLOT_W'(a);
        @(negedge clk);
        tx_req = 1'b0;
        chk("R8 valid low after first edge", int'(tx_valid), 0);
        @(negedge clk);
        chk("R8 valid after second edge", int'(tx_valid), 1);
        chk(btag, int'(tx_byte), int'(exp_b));
        chk((oe_pin || oe_standby) ? "R3 entry enable" : "R4 global off",
            int'(tx_oe), int'(exp_oe));
        chk("R7 delay flag", int'(tx_vdelay), int'(e[12]));
        if (e[11]) dm_m[a] = exp_b;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_7a11));
        rst_n = 1'b0; cm_wr_en = 1'b0; rx_wr = 1'b0; tx_req = 1'b0;
        cm_wr_addr = '0; cm_wr_data = '0; rx_addr = '0; rx_byte = '0;
        tx_addr = '0; oe_pin = 1'b0; oe_standby = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 reset valid", int'(tx_valid), 0);
        chk("R8 reset oe", int'(tx_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Clear every entry, then fill the data memory with no loopback in place
        for (int a = 0; a < NUM_SLOTS; a++) cm_write(a, '0);
        for (int a = 0; a < NUM_SLOTS; a++) rx_write(a, BYTE_W'($urandom));

        // Random mix of switched, processor and loopback entries
        for (int a = 0; a < NUM_SLOTS; a++) begin
            logic [31:0] r;
            logic [ENTRY_W-1:0] d;
            r = $urandom;
            d = {r[6], (r[4:2] == 3'd0), r[5], (r[1:0] == 2'd0), r[15:7]};
            cm_write(a, d);
        end

        // Directed corner cases
        oe_pin = 1'b1;
        cm_write(20, 13'b0_0_1_0_000000000);        // plain target, no loopback
        cm_write(5,  13'b1_1_1_1_0_1010_0101);      // processor 0xA5, loopback
        cm_write(6,  {4'b0_0_1_0, 9'd5});           // switched from slot 5
        cm_write(7,  {4'b0_0_0_0, 9'd20});          // switched from slot 20, disabled
        tx_slot(5, "R1 processor byte directed");
        tx_slot(6, "R5 loopback byte seen");
        rx_write(5, 8'h3C);
        tx_slot(6, "R6 rx write to loopback slot ignored");
        rx_write(20, 8'h5A);
        tx_slot(7, "R9 rx write stored");
        oe_pin = 1'b0;
        tx_slot(5, "R1 processor byte, globals off");

        // Frames under each enable combination, with fresh receive traffic between
        for (int f = 0; f < 4; f++) begin
            oe_pin     = f[0];
            oe_standby = f[1];
            for (int k = 0; k < 64; k++) rx_write(int'($urandom % NUM_SLOTS), BYTE_W'($urandom));
            for (int a = 0; a < NUM_SLOTS; a++) tx_slot(a, "");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule